// File: doc/BRIEF.md
# Enable-Level Mode Selector

This block turns one multi-level enable input into the operating mode of a boost power stage with an input disconnect switch. Two external comparators present the analog level as two digital bits: one is high when the level is above the lower threshold, the other when it is above the upper threshold. Their outputs are synchronised, decoded into a requested mode (shutdown, boost or standby) and accepted only once the request has held steady for a qualification time counted in clock cycles. A request that changes again before that time is discarded and the count starts over.

The accepted mode drives three registered outputs: a boost-enable for the switching regulator, a pass-enable for the high-side disconnect switch, and a shutdown flag that other logic uses to clear protection latch-offs, since entering shutdown is the only way out of a latch-off. Boost is never entered directly. The block always passes through standby and stays there for a programmable entry delay before switching starts. A shutdown or standby request is accepted from any mode, including from boost.

Both delays are parameters in clock cycles (`QUAL_CYC` of at least 2, `ENTRY_CYC` of at least 2). Reset is synchronous and active high.

Top module: `enmode_sel`

## Requirements
- R1: The level is decoded from the synchronised comparator bits. `lvl_above_hi`=1 requests standby, whatever `lvl_above_lo` is. `lvl_above_lo`=1 with `lvl_above_hi`=0 requests boost. Both at 0 request shutdown.
- R2: In shutdown, `boost_en`=0, `pass_en`=0, `sd_clr`=1 and `mode_o`=0.
- R3: In standby, `boost_en`=0, `pass_en`=1, `sd_clr`=0 and `mode_o`=1.
- R4: In boost, `boost_en`=1, `pass_en`=1, `sd_clr`=0 and `mode_o`=2. `mode_o` never takes the value 3.
- R5: When boost is requested from shutdown, standby outputs appear first. `boost_en` then rises at the (QUAL_CYC+ENTRY_CYC+2)th rising edge after the input change. Boost never follows shutdown directly.
- R6: A request held for QUAL_CYC consecutive synchronised samples changes the outputs at the (QUAL_CYC+3)th rising edge after the input change, and not earlier.
- R7: A request that lasts fewer than QUAL_CYC samples leaves the mode unchanged. A later request is counted from zero, with no credit for earlier partial requests.
- R8: While reset is asserted, and at the first edge after it is released, the outputs show shutdown.
- R9: If the request moves away from boost during the standby entry delay, boost is not entered. A later boost request from standby again waits the full QUAL_CYC+ENTRY_CYC+2 edges.
- R10: A qualified shutdown or standby request is taken directly from boost, at the (QUAL_CYC+3)th edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_above_lo | input | 1 | Asynchronous comparator bit: level above lower threshold |
| lvl_above_hi | input | 1 | Asynchronous comparator bit: level above upper threshold |
| boost_en | output | 1 | Enables boost switching |
| pass_en | output | 1 | Turns on the high-side pass switch |
| sd_clr | output | 1 | High in shutdown; clears protection latches |
| mode_o | output | 2 | Current mode: 0 shutdown, 1 standby, 2 boost |

## Verification
A stuck or mis-loaded qualification counter shows at the ports as a mode change that comes a few edges too early or too late after a clean request. It can also show as a short glitch that still switches the mode, visible within QUAL_CYC+3 edges of the stimulus. A wrong state or entry timer shows as boost switching that appears straight after shutdown, or that appears one or more edges off the expected count after standby. Either way it is visible within QUAL_CYC+ENTRY_CYC+2 edges. The bench runs a cycle-accurate model built from the requirements alongside the design and compares all outputs every cycle under random level changes, so any such divergence is reported in the cycle it first appears.

// File: rtl/enmode_pkg.sv
`timescale 1ns/1ps
package enmode_pkg;

  typedef enum logic [1:0] {
    MODE_SHUT  = 2'd0,
    MODE_STBY  = 2'd1,
    MODE_BOOST = 2'd2
  } mode_t;

  // R1: upper comparator dominates, then lower, else shutdown
  function automatic mode_t level_to_mode(input logic above_lo, input logic above_hi);
    if (above_hi)      return MODE_STBY;
    else if (above_lo) return MODE_BOOST;
    else               return MODE_SHUT;
  endfunction

endpackage

// File: rtl/enmode_sync.sv
`timescale 1ns/1ps
module enmode_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/enmode_decode.sv
`timescale 1ns/1ps
module enmode_decode
  import enmode_pkg::*;
(
  input  logic  above_lo,
  input  logic  above_hi,
  output mode_t req
);

  always_comb req = level_to_mode(above_lo, above_hi);

endmodule

// File: rtl/enmode_qual.sv
`timescale 1ns/1ps
module enmode_qual
  import enmode_pkg::*;
#(
  parameter int QUAL_CYC = 2500
) (
  input  logic  clk,
  input  logic  rst,
  input  mode_t req,
  output mode_t acc
);

  localparam int            CW   = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

  mode_t         cand;
  logic [CW-1:0] run;

  // R6/R7: a changed request restarts the run at one; acceptance after QUAL_CYC equal samples
  always_ff @(posedge clk) begin
    if (rst) begin
      cand <= MODE_SHUT;
      run  <= '0;
      acc  <= MODE_SHUT;
    end else if (req != cand) begin
      cand <= req;
      run  <= CW'(1);
    end else if (run == LAST) begin
      acc  <= cand;
    end else begin
      run  <= run + 1'b1;
    end
  end

endmodule

// File: rtl/enmode_seq.sv
`timescale 1ns/1ps
module enmode_seq
  import enmode_pkg::*;
#(
  parameter int ENTRY_CYC = 50000
) (
  input  logic  clk,
  input  logic  rst,
  input  mode_t acc,
  output mode_t mode,
  output logic  boost_en,
  output logic  pass_en,
  output logic  sd_clr
);

  localparam int            TW    = $clog2(ENTRY_CYC + 1);
  localparam logic [TW-1:0] TLAST = TW'(ENTRY_CYC - 1);

  mode_t         nxt;
  logic [TW-1:0] tmr, tmr_nxt;

  always_comb begin
    nxt     = mode;
    tmr_nxt = tmr;
    // R9: entry timer runs only while boost stays requested
    if (acc != MODE_BOOST)
      tmr_nxt = '0;
    else if (mode != MODE_BOOST && tmr != TLAST)
      tmr_nxt = tmr + 1'b1;
    case (acc)
      MODE_SHUT:  nxt = MODE_SHUT;
      MODE_STBY:  nxt = MODE_STBY;
      MODE_BOOST: begin
        // R5: shutdown always goes through standby
        if (mode == MODE_SHUT)
          nxt = MODE_STBY;
        else if (mode == MODE_STBY && tmr == TLAST)
          nxt = MODE_BOOST;
      end
      default:    nxt = MODE_SHUT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= MODE_SHUT;
      tmr      <= '0;
      boost_en <= 1'b0;
      pass_en  <= 1'b0;
      sd_clr   <= 1'b1;
    end else begin
      mode     <= nxt;
      tmr      <= tmr_nxt;
      boost_en <= (nxt == MODE_BOOST);
      pass_en  <= (nxt != MODE_SHUT);
      sd_clr   <= (nxt == MODE_SHUT);
    end
  end

endmodule

// File: rtl/enmode_sel.sv
`timescale 1ns/1ps
module enmode_sel
  import enmode_pkg::*;
#(
  parameter int QUAL_CYC  = 2500,
  parameter int ENTRY_CYC = 50000,
  parameter int SYNC_STG  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lvl_above_lo,
  input  logic       lvl_above_hi,
  output logic       boost_en,
  output logic       pass_en,
  output logic       sd_clr,
  output logic [1:0] mode_o
);

  logic [1:0] lvl_s;
  mode_t      req, acc, mode;

  enmode_sync #(.WIDTH(2), .STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({lvl_above_hi, lvl_above_lo}),
    .q   (lvl_s)
  );

  enmode_decode u_dec (
    .above_lo (lvl_s[0]),
    .above_hi (lvl_s[1]),
    .req      (req)
  );

  enmode_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk (clk),
    .rst (rst),
    .req (req),
    .acc (acc)
  );

  enmode_seq #(.ENTRY_CYC(ENTRY_CYC)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .acc      (acc),
    .mode     (mode),
    .boost_en (boost_en),
    .pass_en  (pass_en),
    .sd_clr   (sd_clr)
  );

  assign mode_o = mode;

endmodule

// File: rtl/enmode_sel_chk.sv
`timescale 1ns/1ps
module enmode_sel_chk #(
  parameter int QUAL_CYC = 2500
) (
  input logic       clk,
  input logic       rst,
  input logic       lvl_above_lo,
  input logic       lvl_above_hi,
  input logic       boost_en,
  input logic       pass_en,
  input logic       sd_clr,
  input logic [1:0] mode_o
);

  localparam int RMAX = QUAL_CYC;
  localparam int RW   = $clog2(RMAX + 1);

  logic [1:0]    prev_lvl;
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    prev_lvl <= {lvl_above_hi, lvl_above_lo};
    if (rst)                                      run <= '0;
    else if ({lvl_above_hi, lvl_above_lo} != prev_lvl) run <= '0;
    else if (run != RW'(RMAX))                    run <= run + 1'b1;
  end

  AST_SHUT_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
    sd_clr |-> (!pass_en && !boost_en && mode_o == 2'd0)); // R2
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    mode_o != 2'd3); // R4
  AST_BOOST_HAS_PASS: assert property (@(posedge clk) disable iff (rst)
    boost_en |-> (pass_en && mode_o == 2'd2)); // R4
  AST_NO_DIRECT_BOOST: assert property (@(posedge clk) disable iff (rst)
    $past(sd_clr) |-> !boost_en); // R5
  AST_BOOST_FROM_STBY: assert property (@(posedge clk) disable iff (rst)
    $rose(boost_en) |-> $past(mode_o) == 2'd1); // R5
  AST_SHUT_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    !$stable(sd_clr) |-> $past(run, 3) >= RW'(QUAL_CYC - 1)); // R6
  AST_RESET_SHUT: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> sd_clr); // R8

endmodule

bind enmode_sel enmode_sel_chk #(.QUAL_CYC(QUAL_CYC)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .lvl_above_lo (lvl_above_lo),
  .lvl_above_hi (lvl_above_hi),
  .boost_en     (boost_en),
  .pass_en      (pass_en),
  .sd_clr       (sd_clr),
  .mode_o       (mode_o)
);

// File: tb/tb_enmode_sel.sv
`timescale 1ns/1ps
module tb_enmode_sel;

  localparam int Q = 6;
  localparam int E = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lo  = 1'b0;
  logic       hi  = 1'b0;
  logic       boost_en, pass_en, sd_clr;
  logic [1:0] mode_o;

  int checks = 0;
  int fails  = 0;
  bit mdl_on = 1'b0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  enmode_sel #(.QUAL_CYC(Q), .ENTRY_CYC(E)) dut (
    .clk (clk), .rst (rst), .lvl_above_lo (lo), .lvl_above_hi (hi),
    .boost_en (boost_en), .pass_en (pass_en), .sd_clr (sd_clr), .mode_o (mode_o)
  );

  // expected {mode, boost, pass, sd} for a mode code (R2, R3, R4)
  function automatic logic [4:0] exp_pack(input int m);
    case (m)
      0:       return {2'd0, 1'b0, 1'b0, 1'b1};
      1:       return {2'd1, 1'b0, 1'b1, 1'b0};
      default: return {2'd2, 1'b1, 1'b1, 1'b0};
    endcase
  endfunction

  // R1 decode: hi -> standby(1), lo -> boost(2), else shutdown(0)
  function automatic int lvl_req(input logic l, input logic h);
    if (h) return 1;
    if (l) return 2;
    return 0;
  endfunction

  task automatic expect_mode(input string tag, input int m);
    logic [4:0] act;
    act = {mode_o, boost_en, pass_en, sd_clr};
    checks++;
    if (act !== exp_pack(m)) begin
      fails++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp_pack(m));
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input int m);
    case (m)
      0:       begin lo = 1'b0; hi = 1'b0; end
      1:       begin lo = 1'b1; hi = 1'b1; end
      default: begin lo = 1'b1; hi = 1'b0; end
    endcase
  endtask

  // cycle model built from R1, R5, R6, R7, R9, R10
  int m_cur, m_run, m_a0, m_a1, m_a2, m_st, m_tmr;
  always @(posedge clk) begin : mdl_upd
    int l;
    int nr;
    if (rst) begin
      m_cur <= 0; m_run <= 0; m_a0 <= 0; m_a1 <= 0; m_a2 <= 0; m_st <= 0; m_tmr <= 0;
    end else begin
      l  = lvl_req(lo, hi);
      nr = (l == m_cur) ? ((m_run < Q) ? m_run + 1 : m_run) : 1;
      m_cur <= l;
      m_run <= nr;
      if (nr >= Q) m_a0 <= l;
      m_a1 <= m_a0;
      m_a2 <= m_a1;
      if (m_a2 != 2) m_tmr <= 0;
      else if (m_st != 2 && m_tmr != E - 1) m_tmr <= m_tmr + 1;
      if (m_a2 == 0) m_st <= 0;
      else if (m_a2 == 1) m_st <= 1;
      else if (m_st == 0) m_st <= 1;
      else if (m_st == 1 && m_tmr == E - 1) m_st <= 2;
    end
  end

  always @(negedge clk) begin
    if (mdl_on && !rst) expect_mode("R6 cycle model", m_st);
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    drive(0);
    rst = 1'b1;
    step(4);
    expect_mode("R8 in reset", 0);
    rst = 1'b0;
    step(1);
    expect_mode("R8 after release", 0);
    expect_mode("R2 shutdown outputs", 0);
    mdl_on = 1'b1;
    step(20);

    // shutdown -> standby -> boost
    drive(2);
    step(Q + 2);
    expect_mode("R6 not before qualification", 0);
    step(1);
    expect_mode("R5 standby first", 1);
    expect_mode("R3 standby outputs", 1);
    step(E - 2);
    expect_mode("R5 still standby before delay", 1);
    step(1);
    expect_mode("R4 boost outputs", 2);
    expect_mode("R1 lower-only is boost", 2);

    // short glitches ignored, count restarts
    drive(1); step(Q - 1); drive(2); step(3 * Q);
    expect_mode("R7 standby glitch ignored", 2);
    drive(0); step(Q - 1); drive(2); step(3 * Q);
    expect_mode("R7 shutdown glitch ignored", 2);
    drive(1); step(Q - 1); drive(2); step(1); drive(1); step(Q - 1); drive(2); step(3 * Q);
    expect_mode("R7 count restarts", 2);

    // boost -> standby directly
    drive(1);
    step(Q + 2);
    expect_mode("R10 boost held", 2);
    step(1);
    expect_mode("R10 boost to standby", 1);

    // aborted entry, then full delay again
    drive(2); step(10); drive(1); step(3 * E);
    expect_mode("R9 aborted entry", 1);
    drive(2);
    step(Q + E + 1);
    expect_mode("R9 full delay again", 1);
    step(1);
    expect_mode("R9 boost after full delay", 2);

    // boost -> shutdown directly
    drive(0);
    step(Q + 2);
    expect_mode("R10 boost before shutdown", 2);
    step(1);
    expect_mode("R10 boost to shutdown", 0);
    step(10);

    // upper bit dominates
    lo = 1'b0; hi = 1'b1;
    step(Q + 3);
    expect_mode("R1 upper bit alone is standby", 1);

    // random holds
    for (int i = 0; i < 400; i++) begin
      drive(int'($urandom % 3));
      step(1 + int'($urandom % (3 * Q)));
    end
    drive(2);
    step(Q + E + 4);
    expect_mode("R5 random phase ends in boost", 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule